// File: doc/BRIEF.md
# Interrupt Request Capture and Dispatch

This block sits between the request pins of a microcoded processor and its instruction decoder. It keeps one pending flop for each of four request sources: a reset request, a non-maskable interrupt, a maskable interrupt and a fast interrupt. The two edge-triggered sources arm on a falling pin edge. The maskable interrupt arms on a low level while the interrupt-disable flag is clear. The reset request arms on every clock while its pin is low. Each flop is released only by its own microcode acknowledge strobe.

At the first step of every instruction, marked by a step-1 strobe, the block freezes a snapshot of the four pending bits together with a select flag. The select flag tells the decoder whether this instruction slot runs special-request microcode or the fetched opcode. While the flag is set, the decoder address field carries the zero-extended snapshot in place of the latched opcode. The microcode then resolves priority among all bits that are set. While a multi-byte opcode is in progress, shown by a non-zero extension opcode field, a capture sees no requests. This keeps the later bytes of the opcode from being displaced.

Top module: `irq_dispatch`

## Requirements
- R1: While `rst_n` is low on a clock edge, the snapshot and the select flag are cleared. Afterwards `special_sel`=0, `pend_snap`=0 and `dec_field` equals `opcode`.
- R2: A high-to-low transition of `nmi_n` between two clock edges arms the non-maskable pending bit (bit 1). Clearing that bit with `ack[1]` while the pin is still low does not re-arm it. Only a new falling edge does.
- R3: `firq_n` behaves as in R2. It arms pending bit 3 and is cleared by `ack[3]`.
- R4: A clock edge at which `irq_n` is low and `irq_disable` is 0 arms pending bit 2. With `irq_disable`=1 the bit is not armed. Once armed, the bit stays set after the pin returns high, until `ack[2]`.
- R5: Every clock edge at which `rst_req_n` is low arms pending bit 0. `ack[0]` has no effect while the pin stays low.
- R6: Each pending bit is cleared only by its own acknowledge bit: ack bit 0 for reset, 1 for NMI, 2 for IRQ and 3 for FIRQ. A set condition in the same cycle as its acknowledge wins.
- R7: On a clock edge with `step1`=1, `pend_snap` takes the pending bits and `special_sel` takes their OR. Both then hold unchanged until the next such edge.
- R8: If `ext_op` is non-zero at a step-1 edge, that capture yields `pend_snap`=0 and `special_sel`=0. The pending flops keep their state for a later capture.
- R9: `dec_field` is combinational. It equals `{zeros, pend_snap}` when `special_sel`=1 and `opcode` otherwise.
- R10: When several requests are pending together, all their bits appear in the snapshot and in `dec_field` without any encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one rising edge per processor step |
| rst_n | input | 1 | Synchronous active-low reset of this block |
| rst_req_n | input | 1 | Reset request pin, active low (pending bit 0) |
| nmi_n | input | 1 | Non-maskable interrupt pin, falling-edge (bit 1) |
| irq_n | input | 1 | Maskable interrupt pin, low level (bit 2) |
| firq_n | input | 1 | Fast interrupt pin, falling-edge (bit 3) |
| irq_disable | input | 1 | Interrupt-disable flag; 1 blocks the maskable source |
| ack | input | 4 | Per-source acknowledge strobes from microcode |
| step1 | input | 1 | High during step 1 of an instruction |
| ext_op | input | EXT_W (2) | Extension opcode bits; non-zero masks capture |
| opcode | input | OP_W (8) | Latched opcode |
| special_sel | output | 1 | Frozen flag: decoder runs special-request code |
| pend_snap | output | 4 | Pending bits frozen at step 1 |
| dec_field | output | OP_W (8) | Decoder address field (snapshot or opcode) |

## Verification
A pin event arms its pending flop at the first rising edge that sees it. It reaches `pend_snap` and `special_sel` only at the next rising edge that has `step1` high, so a request needs at least two edges to become visible. `dec_field` follows `special_sel`, `pend_snap` and `opcode` with no clock. The bench drives every input at the falling edge. It reads the registered outputs at the falling edge that follows the capturing rising edge. It reads the combinational field a short delay after an opcode change, with no edge in between. Pending state that has no port is always read back through a step-1 capture before the next stimulus, which is how the acknowledge and masking cases are shown.

// File: rtl/irq_dispatch_pkg.sv
// Shared constants and types for the interrupt capture and dispatch block.
// Assumes four request sources in a fixed bit order that the decoder relies on.
package irq_dispatch_pkg;

    localparam int NSRC = 4;

    // bit position of each source inside the pending vector
    localparam int SRC_RST  = 0;
    localparam int SRC_NMI  = 1;
    localparam int SRC_IRQ  = 2;
    localparam int SRC_FIRQ = 3;

    // how a pending cell arms itself
    typedef enum logic [1:0] {
        CAP_EDGE   = 2'd0,  // falling edge of pin
        CAP_LEVEL  = 2'd1,  // low level while allowed
        CAP_DIRECT = 2'd2   // every cycle while pin low
    } cap_mode_e;

    // pick the capture mode for a source index
    function automatic cap_mode_e mode_of(input int idx);
        if (idx == SRC_IRQ)      return CAP_LEVEL;
        else if (idx == SRC_RST) return CAP_DIRECT;
        else                     return CAP_EDGE;
    endfunction

endpackage

// File: rtl/irq_req_cell.sv
// One pending-request flop with its arming logic.
// Modes: edge (arms on a pin fall seen between two clocks), level (arms while
// pin low and allow high), direct (arms while pin low). The acknowledge clears
// the flop; an arming condition in the same cycle wins over the acknowledge.
// Assumes pin_n is already synchronous to clk.
module irq_req_cell
    import irq_dispatch_pkg::*;
#(
    parameter cap_mode_e MODE = CAP_EDGE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic allow,
    input  logic ack,
    output logic pending
);

    logic pin_q;
    logic arm;

    // decide whether this cycle arms the flop
    always_comb begin
        case (MODE)
            CAP_EDGE:  arm = pin_q & ~pin_n;
            CAP_LEVEL: arm = ~pin_n & allow;
            default:   arm = ~pin_n;
        endcase
    end

    // previous pin level and pending state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q   <= 1'b0;
            pending <= 1'b0;
        end else begin
            pin_q <= pin_n;
            if (arm)
                pending <= 1'b1;
            else if (ack)
                pending <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_snap_stage.sv
// Step-1 capture of the pending vector and the select flag.
// The capture is masked to zero while any extension opcode bit is set.
// Outputs hold between step-1 edges. Assumes step1 is a one-cycle strobe.
module irq_snap_stage #(
    parameter int N     = 4,
    parameter int EXT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step1,
    input  logic [EXT_W-1:0] ext_op,
    input  logic [N-1:0]     pend,
    output logic [N-1:0]     snap,
    output logic             sel
);

    logic          masked;
    logic [N-1:0]  next_snap;

    // gate the requests while a multi-byte opcode is running
    always_comb begin
        masked    = |ext_op;
        next_snap = masked ? '0 : pend;
    end

    // freeze snapshot and select flag at step 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= '0;
            sel  <= 1'b0;
        end else if (step1) begin
            snap <= next_snap;
            sel  <= |next_snap;
        end
    end

endmodule

// File: rtl/irq_field_mux.sv
// Decoder address field select: zero-extended snapshot or latched opcode.
// Purely combinational. Assumes OP_W >= N.
module irq_field_mux #(
    parameter int OP_W = 8,
    parameter int N    = 4
) (
    input  logic            sel,
    input  logic [N-1:0]    snap,
    input  logic [OP_W-1:0] opcode,
    output logic [OP_W-1:0] field
);

    localparam int PAD = OP_W - N;

    logic [OP_W-1:0] snap_ext;

    generate
        if (PAD > 0) begin : g_pad
            // widen the snapshot with leading zeros
            always_comb snap_ext = {{PAD{1'b0}}, snap};
        end else begin : g_nopad
            // snapshot already fills the field
            always_comb snap_ext = snap;
        end
    endgenerate

    // pick the source the decoder sees
    always_comb field = sel ? snap_ext : opcode;

endmodule

// File: rtl/irq_dispatch.sv
// Interrupt request capture and dispatch (top).
// Four pending cells (reset, NMI, IRQ, FIRQ) feed a step-1 snapshot stage,
// whose flag steers the decoder field between requests and opcode.
// Assumes all pins are synchronous to clk; rst_n is synchronous, active low.
module irq_dispatch
    import irq_dispatch_pkg::*;
#(
    parameter int OP_W  = 8,
    parameter int EXT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_req_n,
    input  logic             nmi_n,
    input  logic             irq_n,
    input  logic             firq_n,
    input  logic             irq_disable,
    input  logic [NSRC-1:0]  ack,
    input  logic             step1,
    input  logic [EXT_W-1:0] ext_op,
    input  logic [OP_W-1:0]  opcode,
    output logic             special_sel,
    output logic [NSRC-1:0]  pend_snap,
    output logic [OP_W-1:0]  dec_field
);

    logic [NSRC-1:0] pin_vec;
    logic [NSRC-1:0] pend;

    // gather pins in pending-bit order
    always_comb begin
        pin_vec           = '1;
        pin_vec[SRC_RST]  = rst_req_n;
        pin_vec[SRC_NMI]  = nmi_n;
        pin_vec[SRC_IRQ]  = irq_n;
        pin_vec[SRC_FIRQ] = firq_n;
    end

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            irq_req_cell #(
                .MODE (mode_of(i))
            ) cell_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin_n   (pin_vec[i]),
                .allow   (~irq_disable),
                .ack     (ack[i]),
                .pending (pend[i])
            );
        end
    endgenerate

    irq_snap_stage #(
        .N     (NSRC),
        .EXT_W (EXT_W)
    ) snap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step1  (step1),
        .ext_op (ext_op),
        .pend   (pend),
        .snap   (pend_snap),
        .sel    (special_sel)
    );

    irq_field_mux #(
        .OP_W (OP_W),
        .N    (NSRC)
    ) mux_i (
        .sel    (special_sel),
        .snap   (pend_snap),
        .opcode (opcode),
        .field  (dec_field)
    );

endmodule

// File: rtl/irq_dispatch_chk.sv
// Property checker for irq_dispatch, attached by bind below.
// Observes ports plus the internal pending vector.
module irq_dispatch_chk
    import irq_dispatch_pkg::*;
#(
    parameter int OP_W  = 8,
    parameter int EXT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_req_n,
    input logic             nmi_n,
    input logic             irq_n,
    input logic             irq_disable,
    input logic [NSRC-1:0]  ack,
    input logic             step1,
    input logic [EXT_W-1:0] ext_op,
    input logic [OP_W-1:0]  opcode,
    input logic [NSRC-1:0]  pend,
    input logic [NSRC-1:0]  pend_snap,
    input logic             special_sel,
    input logic [OP_W-1:0]  dec_field
);

    localparam int PAD = OP_W - NSRC;

    // R2: NMI arms only after a high-to-low pin transition
    a_r2_nmi_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[SRC_NMI]) |-> (!$past(nmi_n) && $past(nmi_n, 2)));

    // R4: IRQ arms only from a low pin with interrupts enabled
    a_r4_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[SRC_IRQ]) |-> $past(!irq_n && !irq_disable));

    // R5: a low reset request always leaves bit 0 set
    a_r5_rst_arm: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req_n |=> pend[SRC_RST]);

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_own
            // R6: a pending bit falls only after its own acknowledge
            a_r6_own_clear: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(pend[g]) |-> ($past(ack[g]) || $past(!rst_n)));
        end
    endgenerate

    // R7: snapshot follows the pending vector at an unmasked step 1
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (step1 && ext_op == '0) |=> (pend_snap == $past(pend)));

    // R7: outputs hold between step-1 edges
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step1 |=> ($stable(pend_snap) && $stable(special_sel)));

    // R8: masked capture yields nothing
    a_r8_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (step1 && ext_op != '0) |=> (pend_snap == '0 && !special_sel));

    // R9: decoder field follows the select flag
    a_r9_field_sel: assert property (@(posedge clk) disable iff (!rst_n)
        special_sel |-> (dec_field == {{PAD{1'b0}}, pend_snap}));

    a_r9_field_op: assert property (@(posedge clk) disable iff (!rst_n)
        !special_sel |-> (dec_field == opcode));

endmodule

bind irq_dispatch irq_dispatch_chk #(
    .OP_W  (OP_W),
    .EXT_W (EXT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_req_n   (rst_req_n),
    .nmi_n       (nmi_n),
    .irq_n       (irq_n),
    .irq_disable (irq_disable),
    .ack         (ack),
    .step1       (step1),
    .ext_op      (ext_op),
    .opcode      (opcode),
    .pend        (pend),
    .pend_snap   (pend_snap),
    .special_sel (special_sel),
    .dec_field   (dec_field)
);

// File: tb/irq_dispatch_tb_top.sv
// Self-checking bench for irq_dispatch: vector table, then directed cases.
module irq_dispatch_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rst_req_n, nmi_n, irq_n, firq_n, irq_disable;
    logic [3:0] ack;
    logic       step1;
    logic [1:0] ext_op;
    logic [7:0] opcode;
    logic       special_sel;
    logic [3:0] pend_snap;
    logic [7:0] dec_field;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;  // 125 MHz

    irq_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .rst_req_n(rst_req_n), .nmi_n(nmi_n),
        .irq_n(irq_n), .firq_n(firq_n), .irq_disable(irq_disable), .ack(ack),
        .step1(step1), .ext_op(ext_op), .opcode(opcode),
        .special_sel(special_sel), .pend_snap(pend_snap), .dec_field(dec_field)
    );

    // request mask bits: 0 reset, 1 nmi, 2 irq, 3 firq
    typedef struct packed {
        logic [3:0] req;
        logic       dis;
        logic [1:0] ext;
        logic [7:0] op;
        logic [3:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{4'b0000, 1'b0, 2'b00, 8'hA9, 4'b0000},  // R9 nothing pending
        '{4'b0010, 1'b0, 2'b00, 8'hEA, 4'b0010},  // R2 nmi
        '{4'b0100, 1'b0, 2'b00, 8'h00, 4'b0100},  // R4 irq
        '{4'b0100, 1'b1, 2'b00, 8'h58, 4'b0000},  // R4 irq disabled
        '{4'b1000, 1'b0, 2'b00, 8'hFF, 4'b1000},  // R3 firq
        '{4'b0001, 1'b0, 2'b00, 8'h4C, 4'b0001},  // R5 reset request
        '{4'b1111, 1'b0, 2'b00, 8'h11, 4'b1111},  // R10 all at once
        '{4'b0110, 1'b0, 2'b01, 8'h22, 4'b0000},  // R8 ext bit 0
        '{4'b1010, 1'b0, 2'b10, 8'h33, 4'b0000},  // R8 ext bit 1
        '{4'b1110, 1'b1, 2'b00, 8'h44, 4'b1010}   // R10 with irq masked
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic capture(input logic [1:0] e);
        ext_op = e;
        step1  = 1'b1;
        step();
        step1  = 1'b0;
        ext_op = 2'b00;
    endtask

    task automatic clear_all();
        ack = 4'hF;
        step();
        ack = 4'h0;
    endtask

    task automatic chk(input string tag, input logic [3:0] es, input logic esel,
                       input logic [7:0] ef);
        n_run++;
        if (pend_snap !== es || special_sel !== esel || dec_field !== ef) begin
            n_fail++;
            $display("FAIL %s: snap=%b sel=%b field=%h expected snap=%b sel=%b field=%h",
                     tag, pend_snap, special_sel, dec_field, es, esel, ef);
        end
    endtask

    task automatic set_pin(input int idx, input logic v);
        case (idx)
            0: rst_req_n = v;
            1: nmi_n     = v;
            2: irq_n     = v;
            default: firq_n = v;
        endcase
    endtask

    // R2 / R3: ack while pin still low does not re-arm; a new fall does
    task automatic edge_hold(input int idx, input string tag);
        logic [3:0] bitv;
        bitv = 4'b0001 << idx;
        set_pin(idx, 1'b0);
        step();
        ack[idx] = 1'b1;
        step();
        ack = 4'h0;
        step();
        step();
        capture(2'b00);
        chk({tag, " no re-arm while low"}, 4'b0000, 1'b0, opcode);
        set_pin(idx, 1'b1);
        step();
        set_pin(idx, 1'b0);
        step();
        set_pin(idx, 1'b1);
        capture(2'b00);
        chk({tag, " new falling edge"}, bitv, 1'b1, {4'b0, bitv});
        clear_all();
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rst_req_n = 1'b1; nmi_n = 1'b1; irq_n = 1'b1; firq_n = 1'b1;
        irq_disable = 1'b0; ack = 4'h0; step1 = 1'b0; ext_op = 2'b00; opcode = 8'hA9;
        @(negedge clk);
        step(); step(); step();
        rst_n = 1'b1;
        chk("R1 reset state", 4'b0000, 1'b0, 8'hA9);
        step(); step();

        // table walk
        for (int v = 0; v < NV; v++) begin
            opcode      = VEC[v].op;
            irq_disable = VEC[v].dis;
            rst_req_n   = ~VEC[v].req[0];
            nmi_n       = ~VEC[v].req[1];
            irq_n       = ~VEC[v].req[2];
            firq_n      = ~VEC[v].req[3];
            step();
            rst_req_n = 1'b1; nmi_n = 1'b1; irq_n = 1'b1; firq_n = 1'b1;
            irq_disable = 1'b0;
            capture(VEC[v].ext);
            chk($sformatf("R7/R9 vector %0d", v), VEC[v].exp, |VEC[v].exp,
                (|VEC[v].exp) ? {4'b0, VEC[v].exp} : VEC[v].op);
            clear_all();
            step();
        end

        opcode = 8'h6C;
        edge_hold(1, "R2");
        edge_hold(3, "R3");

        // R5: held reset request beats its acknowledge
        rst_req_n = 1'b0;
        ack[0] = 1'b1;
        step(); step();
        ack = 4'h0;
        capture(2'b00);
        chk("R5 ack ignored while held", 4'b0001, 1'b1, 8'h01);
        rst_req_n = 1'b1;
        ack[0] = 1'b1;
        step();
        ack = 4'h0;
        capture(2'b00);
        chk("R5 ack after release", 4'b0000, 1'b0, 8'h6C);

        // R4 / R6: irq stays armed, foreign acks do not clear it
        irq_n = 1'b0;
        step();
        irq_n = 1'b1;
        step(); step();
        ack = 4'b1011;
        step();
        ack = 4'h0;
        capture(2'b00);
        chk("R4 R6 irq kept past other acks", 4'b0100, 1'b1, 8'h04);
        ack = 4'b0100;
        step();
        ack = 4'h0;
        capture(2'b00);
        chk("R6 own ack clears irq", 4'b0000, 1'b0, 8'h6C);

        // R4: masked level never arms
        irq_disable = 1'b1;
        irq_n = 1'b0;
        step(); step();
        irq_n = 1'b1;
        step();
        irq_disable = 1'b0;
        capture(2'b00);
        chk("R4 disabled irq ignored", 4'b0000, 1'b0, 8'h6C);

        // R6: edge in the same cycle as its ack still arms
        nmi_n = 1'b0;
        ack[1] = 1'b1;
        step();
        ack = 4'h0;
        nmi_n = 1'b1;
        capture(2'b00);
        chk("R6 set wins over ack", 4'b0010, 1'b1, 8'h02);
        clear_all();
        step();

        // R7: snapshot holds between step-1 edges
        opcode = 8'h5A;
        nmi_n = 1'b0;
        step();
        nmi_n = 1'b1;
        capture(2'b00);
        chk("R7 first capture", 4'b0010, 1'b1, 8'h02);
        firq_n = 1'b0;
        step();
        firq_n = 1'b1;
        opcode = 8'h77;
        step(); step();
        chk("R7 hold without step1", 4'b0010, 1'b1, 8'h02);
        capture(2'b00);
        chk("R7 R10 next capture", 4'b1010, 1'b1, 8'h0A);
        clear_all();
        capture(2'b00);
        chk("R7 empty capture", 4'b0000, 1'b0, 8'h77);

        // R8: masked capture keeps pending state
        irq_n = 1'b0;
        step();
        irq_n = 1'b1;
        capture(2'b11);
        chk("R8 masked capture", 4'b0000, 1'b0, 8'h77);
        capture(2'b00);
        chk("R8 pending retained", 4'b0100, 1'b1, 8'h04);
        clear_all();
        capture(2'b00);

        // R9: field follows opcode without a clock
        opcode = 8'hC3;
        #1;
        chk("R9 combinational opcode", 4'b0000, 1'b0, 8'hC3);

        // R1: reset in mid-operation clears the frozen state
        nmi_n = 1'b0;
        step();
        nmi_n = 1'b1;
        capture(2'b00);
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        chk("R1 reset clears snapshot", 4'b0000, 1'b0, 8'hC3);
        capture(2'b00);
        chk("R1 pending cleared by reset", 4'b0000, 1'b0, 8'hC3);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule